// File: doc/BRIEF.md
# CRC-16 Engine with Seed Load and Bit Transposition

This block computes a 16-bit cyclic redundancy check with the generator polynomial x^16 + x^12 + x^5 + 1 (0x1021). Software first loads a start value into the 16-bit check register. It then presents data one byte per clock, and reads the running check value from the result output at any time. Each absorbed byte updates the register in a single cycle.

A transpose control serves data streams whose bytes arrive least-significant bit first. When it is set, each incoming byte is bit-reversed before it enters the update. The 16-bit result is also presented bit-reversed, so that it matches that convention.

Top module: `crc16_engine`

## Requirements
- R1: While reset is asserted and after its release, the check register holds 0xFFFF; with transpose off, the result output reads 0xFFFF.
- R2: A seed write (`seedWr` high at a rising edge) loads `seedVal` into the check register, and the result shows it from the next cycle on.
- R3: When `seedWr` and `byteValid` are both high at the same edge, the seed is loaded and the byte is discarded.
- R4: With transpose off, a byte presented with `byteValid` high is absorbed at that edge. Bit 7 is processed first, using polynomial 0x1021 with feedback taken from register bit 15 XOR the data bit. The new value appears on the result output one cycle later.
- R5: In a cycle with neither `byteValid` nor `seedWr`, the check register keeps its value.
- R6: With `transposeEn` high at the absorbing edge, bit 0 of the byte is processed first.
- R7: With `transposeEn` high, result bit i equals check register bit 15-i. The output follows `transposeEn` in the same cycle and does not alter the register.
- R8: With seed 0xFFFF, the ASCII bytes "123456789" give 0x29B1 with transpose off and 0x6F91 with transpose on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| seedWr | input | 1 | Load `seedVal` into the check register |
| seedVal | input | 16 | Start value for the check register |
| byteValid | input | 1 | Absorb `byteIn` at this edge |
| byteIn | input | 8 | Data byte |
| transposeEn | input | 1 | Bit-reverse the input bytes and the result |
| crcOut | output | 16 | Current check value, bit-reversed when transpose is set |

## Verification
The hardest case to reach is a seed write that collides with a valid byte while transpose changes around it. Random strobes make such collisions rare, and they must land with non-trivial register contents for any error to show. The bench therefore draws seed writes and bytes independently on every cycle, with transpose switching in phases. It also adds directed collisions and transpose toggles during idle cycles. A reference model in the bench tracks every cycle.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int DATA_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef struct packed {
    logic loadSeed;
    logic absorb;
    logic transpose;
  } crcStrobes_t;
endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedWr,
  input  logic        byteValid,
  input  logic        transposeEn,
  output crcStrobes_t strb
);
  // seed load has priority over a byte in the same cycle
  always_comb begin
    strb.loadSeed  = seedWr;
    strb.absorb    = byteValid & ~seedWr;
    strb.transpose = transposeEn;
  end

  a_r3_seed_wins: assert property (@(posedge clk) disable iff (!rstN)
    seedWr |-> !strb.absorb);
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int W = CRC_W,
  parameter int DW = DATA_W,
  parameter logic [W-1:0] POLY = CRC_POLY,
  parameter logic [W-1:0] RESET_SEED = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  crcStrobes_t   strb,
  input  logic [W-1:0]  seedIn,
  input  logic [DW-1:0] dataIn,
  output logic [W-1:0]  resultOut
);
  logic [W-1:0]  crcReg;
  logic [W-1:0]  crcNext;
  logic [DW-1:0] dataRev;
  logic [DW-1:0] dataEff;
  logic [W-1:0]  crcRev;

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_dataRev
      assign dataRev[gi] = dataIn[DW-1-gi];
    end
    for (gi = 0; gi < W; gi++) begin : g_crcRev
      assign crcRev[gi] = crcReg[W-1-gi];
    end
  endgenerate

  assign dataEff = strb.transpose ? dataRev : dataIn;

  // serial-equivalent update, MSB of the effective byte first
  always_comb begin
    logic [W-1:0] acc;
    logic         fb;
    acc = crcReg;
    for (int i = DW-1; i >= 0; i--) begin
      fb  = acc[W-1] ^ dataEff[i];
      acc = {acc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crcNext = acc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcReg <= RESET_SEED;
    else if (strb.loadSeed) crcReg <= seedIn;
    else if (strb.absorb)   crcReg <= crcNext;
  end

  assign resultOut = strb.transpose ? crcRev : crcReg;

  a_r2_seed_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSeed |=> crcReg == $past(seedIn));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSeed && !strb.absorb) |=> $stable(crcReg));
  a_r4_zero_stays_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.absorb && !strb.loadSeed && crcReg == '0 && dataIn == '0) |=> crcReg == '0);
  a_r7_no_reg_effect: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSeed && !strb.absorb && strb.transpose != $past(strb.transpose)) |=> $stable(crcReg));
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedWr,
  input  logic [15:0] seedVal,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  input  logic        transposeEn,
  output logic [15:0] crcOut
);
  crcStrobes_t strb;

  crc16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .seedWr(seedWr), .byteValid(byteValid),
    .transposeEn(transposeEn), .strb(strb)
  );

  crc16_datapath #(.W(CRC_W), .DW(DATA_W), .POLY(CRC_POLY), .RESET_SEED(16'hFFFF)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .seedIn(seedVal),
    .dataIn(byteIn), .resultOut(crcOut)
  );
endmodule

// File: tb/crc16_engine_tb.sv
module crc16_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seedWr = 1'b0;
  logic [15:0] seedVal = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic transposeEn = 1'b0;
  logic [15:0] crcOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = 16'hFFFF;

  always #2.5 clk = ~clk;

  crc16_engine u_dut (
    .clk(clk), .rstN(rstN), .seedWr(seedWr), .seedVal(seedVal),
    .byteValid(byteValid), .byteIn(byteIn), .transposeEn(transposeEn),
    .crcOut(crcOut)
  );

  function automatic logic [15:0] refStep(input logic [15:0] c, input logic [7:0] b, input logic tr);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) d[k] = tr ? b[k] : b[7-k]; // d[k] = k-th bit processed
    for (int k = 0; k < 8; k++) begin
      if (c[15] ^ d[k]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [15:0] refOut(input logic [15:0] c, input logic tr);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = c[15-k];
    return tr ? r : c;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: crcOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic sw, input logic [15:0] sv,
                      input logic bv, input logic [7:0] bi, input logic tr);
    seedWr = sw; seedVal = sv; byteValid = bv; byteIn = bi; transposeEn = tr;
    @(posedge clk);
    if (sw)      model = sv;
    else if (bv) model = refStep(model, bi, tr);
    @(negedge clk);
    seedWr = 1'b0; byteValid = 1'b0;
    check(req, crcOut, refOut(model, tr));
  endtask

  task automatic runString(input logic tr, input logic [15:0] exp, input string req);
    string s = "123456789";
    step(req, 1'b1, 16'hFFFF, 1'b0, 8'h00, tr);
    for (int i = 0; i < 9; i++) step(req, 1'b0, 16'h0, 1'b1, s[i], tr);
    check(req, refOut(model, tr) == exp ? crcOut : ~crcOut, exp);
    check(req, crcOut, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: crcOut=%h expected=done", crcOut);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    check("R1 in reset", crcOut, 16'hFFFF);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", crcOut, 16'hFFFF);

    step("R2 seed load", 1'b1, 16'h1234, 1'b0, 8'h00, 1'b0);
    step("R4 absorb 0x00", 1'b0, 16'h0, 1'b1, 8'h00, 1'b0);
    step("R4 absorb 0xA5", 1'b0, 16'h0, 1'b1, 8'hA5, 1'b0);
    step("R5 idle hold", 1'b0, 16'hDEAD, 1'b0, 8'h5A, 1'b0);
    step("R3 seed beats byte", 1'b1, 16'hBEEF, 1'b1, 8'h31, 1'b0);
    check("R3 exact seed", crcOut, 16'hBEEF);
    step("R7 transpose view", 1'b0, 16'h0, 1'b0, 8'h00, 1'b1);
    check("R7 reversed seed", crcOut, 16'hF77D);
    step("R7 view off again", 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
    check("R7 register untouched", crcOut, 16'hBEEF);
    step("R6 transposed byte", 1'b0, 16'h0, 1'b1, 8'h01, 1'b1);
    step("R6 transposed byte 2", 1'b0, 16'h0, 1'b1, 8'h80, 1'b1);

    runString(1'b0, 16'h29B1, "R8 check value plain");
    runString(1'b1, 16'h6F91, "R8 check value transposed");

    for (int ph = 0; ph < 20; ph++) begin
      logic tr = $urandom_range(0, 1);
      for (int i = 0; i < 100; i++) begin
        logic sw = ($urandom_range(0, 15) == 0);
        logic bv = $urandom_range(0, 1);
        if ($urandom_range(0, 9) == 0) tr = ~tr;
        step("R4/R5/R6 random", sw, 16'($urandom), bv, 8'($urandom), tr);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule